// File: doc/BRIEF.md
# Fractional Multiply-Accumulate Unit with Convergent Rounding

This block multiplies two signed 32-bit operands and adds the product to a 48-bit accumulator, or subtracts it. Each operation picks one of two number formats. In integer mode the product is taken as a whole number. In fractional mode both operands are signed fractions in 1.31 format. The fractional product is doubled, then rounded or truncated to 40 significant bits, with 8 guard bits above them. Rounding is round-to-nearest with ties to even.

Four condition flags track the result: negative, zero, overflow and extension overflow. A sticky product-overflow bit feeds the overflow flag. A load command writes a 32-bit value into the accumulator. A store command rounds or truncates the accumulator to a 32-bit or a 16-bit fraction and registers it on the read-out port.

Each operation is presented for one cycle with its strobe. The accumulator, the read-out value and the flags all change on the clock edge that follows the strobe.

Top module: `fmac48`

## Requirements
- R1: A synchronous active-high reset clears the accumulator, the read-out register, the sticky product-overflow bit and all four flags.
- R2: The command codes are 2'b00 accumulate, 2'b01 subtract-accumulate, 2'b10 load and 2'b11 store. In integer mode (mode_frac=0), accumulate and subtract add or subtract the low 48 bits of the signed 64-bit product. mode_round has no effect in integer mode.
- R3: In fractional mode with truncation (mode_round=0), the product is doubled. Bits 63..24 of the doubled product are sign-extended to 48 bits and combined with the accumulator. The low 24 bits are dropped.
- R4: In fractional mode with rounding (mode_round=1), the retained 40 bits are incremented when the dropped 24 bits exceed 0x800000. When the dropped bits equal exactly 0x800000, the retained 40 bits are incremented only if their lsb is 1, so the result is even.
- R5: Accumulate, subtract and load set flag_n from bit 47 of the new accumulator and set flag_z when the new accumulator is zero. Store leaves the accumulator and all flags unchanged.
- R6: Product overflow is set in two cases. In integer mode, the 64-bit product does not fit a signed 48-bit value. In fractional mode, both operands are 0x80000000. Product overflow sets the sticky bit. On each accumulate or subtract, flag_v becomes the updated sticky bit OR an overflow of the signed 48-bit sum, so an accumulation overflow alone lasts only until the next such operation.
- R7: flag_ev is set when the new accumulator does not fit a signed 32-bit value (integer mode) or a signed 40-bit value (fractional mode). A later operation that brings the value back into range clears it.
- R8: Load writes op_a into the accumulator. In integer mode the value is sign-extended. In fractional mode op_a is placed in bits 39..8, sign-extended above, with zeros below. Load clears flag_v, flag_ev and the sticky bit.
- R9: Store in fractional 32-bit mode (mode_half16=0) returns accumulator bits 39..8. With rounding, a low byte above 0x80 rounds up, and a low byte of exactly 0x80 rounds to even. The result wraps in 32 bits.
- R10: Store in fractional 16-bit mode (mode_half16=1) returns accumulator bits 39..24 in rd_data[31:16], with zeros in rd_data[15:0]. Rounding uses the low 24 bits, with a tie at 0x800000 resolved to even.
- R11: Store in integer mode returns accumulator bits 31..0. mode_round and mode_half16 have no effect on it.
- R12: All results change on the clock edge after op_valid is high. While op_valid is low, no output changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation strobe, one cycle per operation |
| op_cmd | input | 2 | Command code (see R2) |
| op_a | input | 32 | First operand, or the load value |
| op_b | input | 32 | Second operand |
| mode_frac | input | 1 | 1 fractional, 0 integer |
| mode_round | input | 1 | 1 convergent rounding, 0 truncation |
| mode_half16 | input | 1 | 1 selects 16-bit fractional read-out |
| acc_q | output | 48 | Accumulator |
| rd_data | output | 32 | Registered read-out value |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_ev | output | 1 | Extension overflow flag |

## Verification
Fractional products are driven with dropped bits below one half, above one half, and at exactly one half with both an even and an odd retained lsb. This separates truncation, round-half-up and round-half-to-even. Read-out rounding is tried the same way by loading integers whose low byte or low 24 bits sit at, above and below the tie, including a negative value.

Overflow stimulus is built to tell the two overflow sources apart. A pair of near-limit integer products overflows the 48-bit sum, and the flag then clears. A product of two most-negative fractions sets the sticky bit, which holds until a load. An integer product of two most-positive operands also overflows. A value just past 32 or 40 bits, then pulled back, shows that extension overflow follows the value.

// File: rtl/fmac_pkg.sv
package fmac_pkg;
  typedef enum logic [1:0] {
    CMD_ACC   = 2'b00,
    CMD_SUB   = 2'b01,
    CMD_LOAD  = 2'b10,
    CMD_STORE = 2'b11
  } fmac_cmd_e;
endpackage

// File: rtl/fmac_prod.sv
// Signed product, fractional alignment, convergent rounding, product overflow.
module fmac_prod #(
  parameter int OP_W    = 32,
  parameter int GUARD_W = 8,
  localparam int PROD_W = 2 * OP_W,
  localparam int KEEP_W = OP_W + GUARD_W,
  localparam int ACC_W  = KEEP_W + GUARD_W,
  localparam int DROP_W = PROD_W - KEEP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OP_W-1:0]   a,
  input  logic [OP_W-1:0]   b,
  input  logic              frac,
  input  logic              rnd,
  output logic [ACC_W-1:0]  prod_acc,
  output logic              prod_ovf
);
  localparam logic [DROP_W-1:0] HALF_PT = {1'b1, {(DROP_W-1){1'b0}}};
  localparam logic [OP_W-1:0]   OP_MIN  = {1'b1, {(OP_W-1){1'b0}}};

  logic signed [PROD_W-1:0] a_x, b_x, full;
  logic [PROD_W-1:0]        dbl;
  logic [KEEP_W-1:0]        keep;
  logic [DROP_W-1:0]        drop;
  logic                     up;
  logic [ACC_W-1:0]         frac_val;
  logic [PROD_W-ACC_W:0]    int_top;
  logic                     int_ovf, frac_ovf;

  assign a_x  = PROD_W'($signed(a));
  assign b_x  = PROD_W'($signed(b));
  assign full = a_x * b_x;

  // Fractional alignment: doubled product, upper KEEP_W bits retained.
  assign dbl  = {full[PROD_W-2:0], 1'b0};
  assign keep = dbl[PROD_W-1:DROP_W];
  assign drop = dbl[DROP_W-1:0];
  assign up   = rnd && ((drop > HALF_PT) || ((drop == HALF_PT) && keep[0]));
  assign frac_val = ACC_W'($signed(keep)) + {{(ACC_W-1){1'b0}}, up};

  assign int_top  = full[PROD_W-1:ACC_W-1];
  assign int_ovf  = !((&int_top) || !(|int_top));
  assign frac_ovf = full[PROD_W-1] ^ full[PROD_W-2];

  assign prod_acc = frac ? frac_val : full[ACC_W-1:0];
  assign prod_ovf = frac ? frac_ovf : int_ovf;

  AST_FRAC_OVF_ONLY_MIN: assert property (@(posedge clk) disable iff (rst)
    (frac && prod_ovf) |-> (a == OP_MIN && b == OP_MIN)); // R6
endmodule

// File: rtl/fmac_rdout.sv
// Read-out formatter: integer, 32-bit fraction or 16-bit fraction.
module fmac_rdout #(
  parameter int OP_W    = 32,
  parameter int GUARD_W = 8,
  localparam int KEEP_W = OP_W + GUARD_W,
  localparam int ACC_W  = KEEP_W + GUARD_W,
  localparam int HALF_W = OP_W / 2,
  localparam int LO16_W = KEEP_W - HALF_W
) (
  input  logic [ACC_W-1:0] acc,
  input  logic             frac,
  input  logic             rnd,
  input  logic             half,
  output logic [OP_W-1:0]  rd_val
);
  localparam logic [GUARD_W-1:0] TIE32 = {1'b1, {(GUARD_W-1){1'b0}}};
  localparam logic [LO16_W-1:0]  TIE16 = {1'b1, {(LO16_W-1){1'b0}}};

  logic [OP_W-1:0]    base32, r32;
  logic [GUARD_W-1:0] lo32;
  logic [HALF_W-1:0]  base16, r16;
  logic [LO16_W-1:0]  lo16;
  logic               up32, up16;

  assign base32 = acc[KEEP_W-1:GUARD_W];
  assign lo32   = acc[GUARD_W-1:0];
  assign up32   = rnd && ((lo32 > TIE32) || ((lo32 == TIE32) && base32[0]));
  assign r32    = base32 + {{(OP_W-1){1'b0}}, up32};

  assign base16 = acc[KEEP_W-1:LO16_W];
  assign lo16   = acc[LO16_W-1:0];
  assign up16   = rnd && ((lo16 > TIE16) || ((lo16 == TIE16) && base16[0]));
  assign r16    = base16 + {{(HALF_W-1){1'b0}}, up16};

  always_comb begin
    if (!frac)     rd_val = acc[OP_W-1:0];
    else if (half) rd_val = {r16, {HALF_W{1'b0}}};
    else           rd_val = r32;
  end
endmodule

// File: rtl/fmac48.sv
// Multiply-accumulate unit with 48-bit accumulator and condition flags.
module fmac48
  import fmac_pkg::*;
#(
  parameter int OP_W    = 32,
  parameter int GUARD_W = 8,
  localparam int KEEP_W = OP_W + GUARD_W,
  localparam int ACC_W  = KEEP_W + GUARD_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_valid,
  input  logic [1:0]       op_cmd,
  input  logic [OP_W-1:0]  op_a,
  input  logic [OP_W-1:0]  op_b,
  input  logic             mode_frac,
  input  logic             mode_round,
  input  logic             mode_half16,
  output logic [ACC_W-1:0] acc_q,
  output logic [OP_W-1:0]  rd_data,
  output logic             flag_n,
  output logic             flag_z,
  output logic             flag_v,
  output logic             flag_ev
);
  logic [ACC_W-1:0] prod_acc, res, ld_val;
  logic             prod_ovf, pov_q, pov_nxt, acc_ovf;
  logic [ACC_W:0]   sum;
  logic [OP_W-1:0]  rd_val;
  logic [ACC_W-KEEP_W:0] res_top_f, ld_top_f;
  logic [ACC_W-OP_W:0]   res_top_i;
  logic             res_ev;
  fmac_cmd_e        cmd;

  assign cmd = fmac_cmd_e'(op_cmd);

  fmac_prod #(.OP_W(OP_W), .GUARD_W(GUARD_W)) u_prod (
    .clk(clk), .rst(rst), .a(op_a), .b(op_b),
    .frac(mode_frac), .rnd(mode_round),
    .prod_acc(prod_acc), .prod_ovf(prod_ovf)
  );

  fmac_rdout #(.OP_W(OP_W), .GUARD_W(GUARD_W)) u_rdout (
    .acc(acc_q), .frac(mode_frac), .rnd(mode_round), .half(mode_half16),
    .rd_val(rd_val)
  );

  // One extra bit on the sum exposes a 48-bit overflow.
  always_comb begin
    if (cmd == CMD_SUB) sum = {acc_q[ACC_W-1], acc_q} - {prod_acc[ACC_W-1], prod_acc};
    else                sum = {acc_q[ACC_W-1], acc_q} + {prod_acc[ACC_W-1], prod_acc};
  end
  assign res     = sum[ACC_W-1:0];
  assign acc_ovf = sum[ACC_W] ^ sum[ACC_W-1];
  assign pov_nxt = pov_q | prod_ovf;

  assign res_top_f = res[ACC_W-1:KEEP_W-1];
  assign res_top_i = res[ACC_W-1:OP_W-1];
  assign res_ev    = mode_frac ? !((&res_top_f) || !(|res_top_f))
                               : !((&res_top_i) || !(|res_top_i));

  assign ld_val   = mode_frac ? ACC_W'($signed({op_a, {GUARD_W{1'b0}}}))
                              : ACC_W'($signed(op_a));
  assign ld_top_f = '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      rd_data <= '0;
      pov_q   <= 1'b0;
      flag_n  <= 1'b0;
      flag_z  <= 1'b0;
      flag_v  <= 1'b0;
      flag_ev <= 1'b0;
    end else if (op_valid) begin
      case (cmd)
        CMD_ACC, CMD_SUB: begin
          acc_q   <= res;
          pov_q   <= pov_nxt;
          flag_n  <= res[ACC_W-1];
          flag_z  <= (res == '0);
          flag_v  <= pov_nxt | acc_ovf;
          flag_ev <= res_ev;
        end
        CMD_LOAD: begin
          acc_q   <= ld_val;
          pov_q   <= 1'b0;
          flag_n  <= ld_val[ACC_W-1];
          flag_z  <= (ld_val == '0);
          flag_v  <= 1'b0;
          flag_ev <= 1'b0;
        end
        default: rd_data <= rd_val;
      endcase
    end
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> ($stable(acc_q) && $stable(rd_data)
                   && $stable({flag_n, flag_z, flag_v, flag_ev}))); // R12
  AST_STORE_KEEPS_STATE: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_cmd == 2'b11) |=> ($stable(acc_q)
                   && $stable({flag_n, flag_z, flag_v, flag_ev}))); // R5
  AST_LOAD_CLEARS_OVF: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_cmd == 2'b10) |=> (!flag_v && !flag_ev)); // R8
  AST_ZERO_MATCHES_ACC: assert property (@(posedge clk) disable iff (rst)
    flag_z |-> (acc_q == '0)); // R5
  AST_NEG_MATCHES_SIGN: assert property (@(posedge clk) disable iff (rst)
    flag_n |-> acc_q[ACC_W-1]); // R5
  AST_LOAD_TOP_UNUSED: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_cmd == 2'b10 && mode_frac) |=> (acc_q[GUARD_W-1:0] == ld_top_f[GUARD_W-1:0])); // R8
endmodule

// File: tb/fmac48_tb.sv
module fmac48_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        op_valid;
  logic [1:0]  op_cmd;
  logic [31:0] op_a, op_b;
  logic        mode_frac, mode_round, mode_half16;
  logic [47:0] acc_q;
  logic [31:0] rd_data;
  logic        flag_n, flag_z, flag_v, flag_ev;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  fmac48 u_dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_cmd(op_cmd),
    .op_a(op_a), .op_b(op_b), .mode_frac(mode_frac), .mode_round(mode_round),
    .mode_half16(mode_half16), .acc_q(acc_q), .rd_data(rd_data),
    .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_ev(flag_ev)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Present one operation for a single cycle; returns after results are registered.
  task automatic op(input logic [1:0] c, input logic [31:0] a, input logic [31:0] b,
                    input logic fr, input logic rn, input logic hf);
    @(negedge clk);
    op_valid = 1'b1; op_cmd = c; op_a = a; op_b = b;
    mode_frac = fr; mode_round = rn; mode_half16 = hf;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic chk_flags(input string tag, input logic [3:0] exp_nzvx);
    chk(tag, {60'h0, flag_n, flag_z, flag_v, flag_ev}, {60'h0, exp_nzvx});
  endtask

  task automatic t_reset;
    chk("R1 acc after reset", {16'h0, acc_q}, 64'h0);
    chk("R1 rd_data after reset", {32'h0, rd_data}, 64'h0);
    chk_flags("R1 flags after reset", 4'b0000);
  endtask

  task automatic t_int_mac;
    op(2'b10, 32'h0, 32'h0, 1'b0, 1'b0, 1'b0);
    chk_flags("R5 load zero sets Z", 4'b0100);
    op(2'b00, 32'd3, 32'hFFFF_FFFB, 1'b0, 1'b0, 1'b0);
    chk("R2 int 3*-5", {16'h0, acc_q}, 64'hFFFF_FFFF_FFF1);
    chk_flags("R5 negative result", 4'b1000);
    op(2'b01, 32'hFFFF_FFF1, 32'd1, 1'b0, 1'b0, 1'b0);
    chk("R2 int subtract to zero", {16'h0, acc_q}, 64'h0);
    chk_flags("R5 zero result", 4'b0100);
    op(2'b00, 32'd7, 32'd3, 1'b0, 1'b1, 1'b0);
    chk("R2 round ignored in int mode", {16'h0, acc_q}, 64'd21);
  endtask

  task automatic t_idle_and_store_int;
    @(negedge clk);
    op_cmd = 2'b00; op_a = 32'd100; op_b = 32'd100; mode_frac = 1'b0;
    repeat (3) @(negedge clk);
    chk("R12 idle leaves acc", {16'h0, acc_q}, 64'd21);
    op(2'b11, 32'h0, 32'h0, 1'b0, 1'b1, 1'b1);
    chk("R11 int store ignores round/half", {32'h0, rd_data}, 64'd21);
    chk("R5 store leaves acc", {16'h0, acc_q}, 64'd21);
    chk_flags("R5 store leaves flags", 4'b0000);
  endtask

  task automatic t_frac_product;
    // 0x00500000: doubled product low 24 = 0xA00000 (above half), retained 0
    op(2'b10, 32'h0, 32'h0, 1'b1, 1'b0, 1'b0);
    op(2'b00, 32'h0050_0000, 32'd1, 1'b1, 1'b0, 1'b0);
    chk("R3 frac truncate drops low bits", {16'h0, acc_q}, 64'h0);
    op(2'b10, 32'h0, 32'h0, 1'b1, 1'b0, 1'b0);
    op(2'b00, 32'h0050_0000, 32'd1, 1'b1, 1'b1, 1'b0);
    chk("R4 frac round above half", {16'h0, acc_q}, 64'h1);
    // 0x00C00000: retained 1, dropped exactly 0x800000
    op(2'b10, 32'h0, 32'h0, 1'b1, 1'b0, 1'b0);
    op(2'b00, 32'h00C0_0000, 32'd1, 1'b1, 1'b0, 1'b0);
    chk("R3 frac truncate tie", {16'h0, acc_q}, 64'h1);
    op(2'b10, 32'h0, 32'h0, 1'b1, 1'b0, 1'b0);
    op(2'b00, 32'h00C0_0000, 32'd1, 1'b1, 1'b1, 1'b0);
    chk("R4 tie with odd lsb rounds up", {16'h0, acc_q}, 64'h2);
    // 0x00400000: retained 0, dropped exactly 0x800000
    op(2'b10, 32'h0, 32'h0, 1'b1, 1'b0, 1'b0);
    op(2'b00, 32'h0040_0000, 32'd1, 1'b1, 1'b1, 1'b0);
    chk("R4 tie with even lsb stays", {16'h0, acc_q}, 64'h0);
  endtask

  task automatic t_overflow;
    op(2'b10, 32'h0, 32'h0, 1'b0, 1'b0, 1'b0);
    op(2'b00, 32'h0080_0000, 32'h00FF_FFFF, 1'b0, 1'b0, 1'b0);
    chk("R7 int large product", {16'h0, acc_q}, 64'h7FFF_FF80_0000);
    chk_flags("R7 EV past 32 bits", 4'b0001);
    op(2'b00, 32'h0080_0000, 32'h00FF_FFFF, 1'b0, 1'b0, 1'b0);
    chk("R6 sum wraps", {16'h0, acc_q}, 64'hFFFF_FF00_0000);
    chk_flags("R6 accumulation overflow", 4'b1010);
    op(2'b00, 32'h0, 32'h0, 1'b0, 1'b0, 1'b0);
    chk_flags("R6 accumulation overflow not sticky", 4'b1000);
    op(2'b10, 32'h0, 32'h0, 1'b1, 1'b0, 1'b0);
    op(2'b00, 32'h8000_0000, 32'h8000_0000, 1'b1, 1'b0, 1'b0);
    chk("R6 frac min*min value", {16'h0, acc_q}, 64'hFF80_0000_0000);
    chk_flags("R6 frac product overflow", 4'b1010);
    op(2'b00, 32'h0, 32'h0, 1'b1, 1'b0, 1'b0);
    chk_flags("R6 product overflow sticky", 4'b1010);
    op(2'b10, 32'h0, 32'h0, 1'b1, 1'b0, 1'b0);
    chk_flags("R8 load clears V", 4'b0100);
    op(2'b00, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b0, 1'b0, 1'b0);
    chk("R6 int product overflow value", {16'h0, acc_q}, 64'hFFFF_0000_0001);
    chk("R6 int product overflow V", {63'h0, flag_v}, 64'h1);
  endtask

  task automatic t_ext_overflow;
    op(2'b10, 32'h7FFF_FFFF, 32'h0, 1'b0, 1'b0, 1'b0);
    chk("R8 int load sign-extended", {16'h0, acc_q}, 64'h7FFF_FFFF);
    op(2'b00, 32'd1, 32'd1, 1'b0, 1'b0, 1'b0);
    chk_flags("R7 EV set past 32 bits", 4'b0001);
    op(2'b01, 32'd1, 32'd1, 1'b0, 1'b0, 1'b0);
    chk_flags("R7 EV clears back in range", 4'b0000);
    op(2'b10, 32'h7FFF_FFFF, 32'h0, 1'b1, 1'b0, 1'b0);
    chk("R8 frac load placement", {16'h0, acc_q}, 64'h7F_FFFF_FF00);
    op(2'b00, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b1, 1'b0, 1'b0);
    chk("R7 frac sum value", {16'h0, acc_q}, 64'hFF_FFFF_FD00);
    chk_flags("R7 EV past 40 bits", 4'b0001);
  endtask

  task automatic t_readout;
    op(2'b10, 32'h1234_5678, 32'h0, 1'b1, 1'b0, 1'b0);
    op(2'b11, 32'h0, 32'h0, 1'b1, 1'b0, 1'b0);
    chk("R9 frac load round trip", {32'h0, rd_data}, 64'h1234_5678);
    op(2'b10, 32'h180, 32'h0, 1'b0, 1'b0, 1'b0);
    op(2'b11, 32'h0, 32'h0, 1'b1, 1'b0, 1'b0);
    chk("R9 truncate drops low byte", {32'h0, rd_data}, 64'h1);
    op(2'b11, 32'h0, 32'h0, 1'b1, 1'b1, 1'b0);
    chk("R9 tie odd rounds up", {32'h0, rd_data}, 64'h2);
    op(2'b10, 32'h080, 32'h0, 1'b0, 1'b0, 1'b0);
    op(2'b11, 32'h0, 32'h0, 1'b1, 1'b1, 1'b0);
    chk("R9 tie even stays", {32'h0, rd_data}, 64'h0);
    op(2'b10, 32'h281, 32'h0, 1'b0, 1'b0, 1'b0);
    op(2'b11, 32'h0, 32'h0, 1'b1, 1'b1, 1'b0);
    chk("R9 above half rounds up", {32'h0, rd_data}, 64'h3);
    op(2'b10, 32'h0180_0000, 32'h0, 1'b0, 1'b0, 1'b0);
    op(2'b11, 32'h0, 32'h0, 1'b1, 1'b0, 1'b1);
    chk("R10 half truncate", {32'h0, rd_data}, 64'h0001_0000);
    op(2'b11, 32'h0, 32'h0, 1'b1, 1'b1, 1'b1);
    chk("R10 half tie odd rounds up", {32'h0, rd_data}, 64'h0002_0000);
    op(2'b10, 32'h0080_0000, 32'h0, 1'b0, 1'b0, 1'b0);
    op(2'b11, 32'h0, 32'h0, 1'b1, 1'b1, 1'b1);
    chk("R10 half tie even stays", {32'h0, rd_data}, 64'h0);
    op(2'b10, 32'hFF40_0000, 32'h0, 1'b0, 1'b0, 1'b0);
    op(2'b11, 32'h0, 32'h0, 1'b1, 1'b1, 1'b1);
    chk("R10 half negative below tie", {32'h0, rd_data}, 64'hFFFF_0000);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; op_valid = 1'b0; op_cmd = 2'b00; op_a = '0; op_b = '0;
    mode_frac = 1'b0; mode_round = 1'b0; mode_half16 = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_int_mac();
    t_idle_and_store_int();
    t_frac_product();
    t_overflow();
    t_ext_overflow();
    t_readout();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule